// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Selector

This block decides which of a small set of CAN transmit mailboxes is handed to the protocol engine next. Each mailbox presents a pending flag, a 29-bit identifier field and a flag marking extended format. The selector watches these inputs and produces a registered grant: a valid flag, a mailbox index and the same choice in one-hot form. The grant is recomputed on every clock edge, so it follows any change in the pending set one cycle later.

Two policies are supported. In identifier order, the mailbox whose frame would win bus arbitration is chosen: smaller identifiers first, a standard frame ahead of an extended frame with the same leading bits, and the lower mailbox number when everything is equal. In arrival order, mailboxes are served in the order their pending flags rose, which keeps a segmented message in sequence. The policy input is taken over only while no mailbox is pending, so a running sequence is never reordered.

The grant is a status view of the current choice, not a stream item: there is no handshake and no back-pressure. The engine reads the grant whenever it is ready to start a frame, and the mailbox logic clears the pending flag once the frame is done or aborted.

Top module: `can_txmb_prio_sel`

## Requirements
- R1: In identifier order, the pending mailbox with the smallest comparison key is granted. The key is the 29-bit aligned identifier followed by one extra low bit that holds the extended flag (1 = extended).
- R2: When two pending mailboxes have equal keys, the one with the lower mailbox number is granted.
- R3: A standard identifier uses bits 10:0 of its mailbox field. It is placed in key identifier bits 28:18 with zeros below. An extended identifier uses all 29 bits as given. A standard frame therefore wins over an extended frame whose bits 28:18 match and whose bits 17:0 are zero.
- R4: Only mailboxes with their pending flag high take part. With none pending, the grant valid flag is 0, the index is 0 and the one-hot grant is all zeros. Otherwise the one-hot grant has bit `index` set alone.
- R5: In arrival order (policy input 1), the pending mailbox whose pending flag rose earliest is granted, whatever the identifiers.
- R6: In arrival order, mailboxes whose pending flags rise in the same cycle are ordered by mailbox number, lowest first.
- R7: The arrival order stays correct over any length of run, including when one mailbox waits while others leave and rejoin many times.
- R8: The policy input is sampled on a clock edge only when no pending flag is high at that edge. A change made while any mailbox is pending has no effect until the set has been empty at an edge.
- R9: The grant outputs after a clock edge reflect the pending flags, identifiers and extended flags present at that edge.
- R10: During and right after reset, the grant valid flag is 0 and the policy is identifier order.
- R11: A mailbox whose pending flag falls and rises again joins the arrival order as the newest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode_i | input | 1 | Policy select: 0 identifier order, 1 arrival order |
| pend_i | input | NUM_MB | Pending flag per mailbox |
| ident_i | input | NUM_MB*29 | Identifier field per mailbox, mailbox i at bits [i*29 +: 29] |
| ext_i | input | NUM_MB | Extended-format flag per mailbox |
| grant_valid_o | output | 1 | A mailbox is granted |
| grant_idx_o | output | IDX_W | Index of the granted mailbox |
| grant_oh_o | output | NUM_MB | One-hot form of the grant |

## Verification
The bench builds the selector with its default of three mailboxes. This gives a 2-bit index and a 2-bit queue position, and covers every index value, every way three mailboxes can leave and rejoin the arrival order, and all three-way identifier ties. Identifiers are drawn from a tiny range so that equal keys and standard-versus-extended collisions occur often. Policy changes are thrown in while requests are pending, to exercise the rule that the policy is only taken over when the set is idle.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int KEY_W = ID_W + 1;

  typedef logic [ID_W-1:0]  ident_t;
  typedef logic [KEY_W-1:0] key_t;

  // arbitration key: aligned identifier, then the extended flag as lowest bit
  function automatic key_t arb_key(ident_t id, logic ext);
    ident_t al;
    al = ext ? id : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
    return {al, ext};
  endfunction
endpackage

// File: rtl/mb_order_tracker.sv
module mb_order_tracker #(
  parameter int NUM_MB = 3,
  parameter int POS_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_MB-1:0]            pend_i,
  output logic [NUM_MB-1:0][POS_W-1:0] pos_nxt_o
);
  localparam int CNT_W = $clog2(NUM_MB + 1);

  logic [NUM_MB-1:0]            pend_q;
  logic [NUM_MB-1:0][POS_W-1:0] pos_q;

  // queue position: 0 is oldest; survivors close gaps, newcomers go behind
  always_comb begin
    logic [CNT_W-1:0] stay_cnt;
    logic [CNT_W-1:0] new_seen;
    logic [CNT_W-1:0] drop;
    stay_cnt = '0;
    new_seen = '0;
    drop     = '0;
    for (int j = 0; j < NUM_MB; j++) begin
      if (pend_q[j] && pend_i[j]) stay_cnt = stay_cnt + 1'b1;
    end
    for (int i = 0; i < NUM_MB; i++) begin
      pos_nxt_o[i] = '0;
      if (pend_i[i]) begin
        if (pend_q[i]) begin
          drop = '0;
          for (int j = 0; j < NUM_MB; j++) begin
            if (pend_q[j] && !pend_i[j] && (pos_q[j] < pos_q[i])) drop = drop + 1'b1;
          end
          pos_nxt_o[i] = pos_q[i] - POS_W'(drop);
        end else begin
          pos_nxt_o[i] = POS_W'(stay_cnt + new_seen);
          new_seen     = new_seen + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pos_q  <= '0;
    end else begin
      pend_q <= pend_i;
      pos_q  <= pos_nxt_o;
    end
  end

  for (genvar i = 0; i < NUM_MB; i++) begin : g_bound
    p_pos_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] |-> (int'(pos_q[i]) < $countones(pend_q)));
    for (genvar j = i + 1; j < NUM_MB; j++) begin : g_pair
      p_pos_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && pend_q[j]) |-> (pos_q[i] != pos_q[j]));
    end
  end
endmodule

// File: rtl/mb_key_builder.sv
module mb_key_builder
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int POS_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_mode_i,
  input  logic [NUM_MB*ID_W-1:0]       ident_i,
  input  logic [NUM_MB-1:0]            ext_i,
  input  logic [NUM_MB-1:0][POS_W-1:0] pos_i,
  output key_t [NUM_MB-1:0]            key_o
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_key
    assign key_o[i] = fifo_mode_i ? key_t'(pos_i[i])
                                  : arb_key(ident_i[i*ID_W +: ID_W], ext_i[i]);

    p_std_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_mode_i && !ext_i[i]) |-> (key_o[i][ID_W-STD_W:0] == '0));
  end
endmodule

// File: rtl/mb_min_arbiter.sv
module mb_min_arbiter
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MB-1:0] cand_i,
  input  key_t [NUM_MB-1:0] key_i,
  output logic              win_valid_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  // ascending scan with strict compare: ties stay with the lower index
  always_comb begin
    key_t best;
    best        = '1;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (cand_i[i] && (!win_valid_o || key_i[i] < best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best        = key_i[i];
      end
    end
  end

  for (genvar j = 0; j < NUM_MB; j++) begin : g_chk
    p_min_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid_o && cand_i[j]) |-> (key_i[win_idx_o] <= key_i[j]));
    p_tie_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid_o && cand_i[j] && key_i[j] == key_i[win_idx_o]) |-> (int'(win_idx_o) <= j));
  end
endmodule

// File: rtl/can_txmb_prio_sel.sv
module can_txmb_prio_sel
  import can_txmb_pkg::*;
#(
  parameter  int NUM_MB = 3,
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fifo_mode_i,
  input  logic [NUM_MB-1:0]      pend_i,
  input  logic [NUM_MB*ID_W-1:0] ident_i,
  input  logic [NUM_MB-1:0]      ext_i,
  output logic                   grant_valid_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic [NUM_MB-1:0]      grant_oh_o
);
  localparam int POS_W = IDX_W;

  logic                         mode_q;
  logic [NUM_MB-1:0][POS_W-1:0] pos_nxt;
  key_t [NUM_MB-1:0]            keys;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;

  // policy only changes hands while the mailbox set is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= 1'b0;
    else if (pend_i == '0) mode_q <= fifo_mode_i;
  end

  mb_order_tracker #(.NUM_MB(NUM_MB), .POS_W(POS_W)) u_order (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .pos_nxt_o(pos_nxt)
  );

  mb_key_builder #(.NUM_MB(NUM_MB), .POS_W(POS_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .fifo_mode_i(mode_q), .ident_i(ident_i),
    .ext_i(ext_i), .pos_i(pos_nxt), .key_o(keys)
  );

  mb_min_arbiter #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand_i(pend_i), .key_i(keys),
    .win_valid_o(win_valid), .win_idx_o(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid_o <= 1'b0;
      grant_idx_o   <= '0;
      grant_oh_o    <= '0;
    end else begin
      grant_valid_o <= win_valid;
      grant_idx_o   <= win_valid ? win_idx : '0;
      grant_oh_o    <= win_valid ? (NUM_MB'(1) << win_idx) : '0;
    end
  end

  p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (grant_valid_o == $past(pend_i != '0)));
  p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (($past(pend_i) & grant_oh_o) != '0));
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o |-> (grant_oh_o == '0 && grant_idx_o == '0));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |=> $stable(mode_q));
endmodule

// File: tb/test_can_txmb_prio_sel.sv
`timescale 1ns/1ps
module test_can_txmb_prio_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode_i = 1'b0;
  logic [2:0]  pend_i = '0;
  logic [86:0] ident_i = '0;
  logic [2:0]  ext_i = '0;
  logic        grant_valid_o;
  logic [1:0]  grant_idx_o;
  logic [2:0]  grant_oh_o;

  can_txmb_prio_sel #(.NUM_MB(3)) i_can_txmb_prio_sel (
    .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .pend_i(pend_i),
    .ident_i(ident_i), .ext_i(ext_i), .grant_valid_o(grant_valid_o),
    .grant_idx_o(grant_idx_o), .grant_oh_o(grant_oh_o)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  int         order[$];
  logic       ref_mode = 1'b0;
  logic [2:0] prev_pend = '0;

  function automatic logic [29:0] ref_key(logic [28:0] id, logic e);
    logic [28:0] al;
    if (e) al = id;
    else   al = {id[10:0], 18'd0};
    return {al, e};
  endfunction

  task automatic step(input logic [2:0] p, input logic [28:0] a, input logic [28:0] b,
                      input logic [28:0] c, input logic [2:0] e, input logic m, input string tag);
    logic [2:0] ex;
    logic [29:0] best;
    logic [29:0] k;
    @(negedge clk);
    pend_i = p; ident_i = {c, b, a}; ext_i = e; fifo_mode_i = m;
    for (int q = order.size() - 1; q >= 0; q--)
      if (!p[order[q]]) order.delete(q);
    for (int i = 0; i < 3; i++)
      if (p[i] && !prev_pend[i]) order.push_back(i);
    ex = 3'b000;
    if (p != 0) begin
      if (ref_mode) ex = {1'b1, 2'(order[0])};
      else begin
        best = '1;
        for (int i = 0; i < 3; i++) begin
          k = ref_key(i == 0 ? a : (i == 1 ? b : c), e[i]);
          if (p[i] && (!ex[2] || k < best)) begin ex = {1'b1, 2'(i)}; best = k; end
        end
      end
    end
    if (p == 0) ref_mode = m;
    prev_pend = p;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  // monitor: scoreboard pop after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] ex;
      string tg;
      logic [2:0] ex_oh;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      ex_oh = ex[2] ? (3'b001 << ex[1:0]) : 3'b000;
      checks++;
      if ({grant_valid_o, grant_idx_o} !== ex || grant_oh_o !== ex_oh) begin
        failures++;
        $display("FAIL %s: got v=%0b idx=%0d oh=%b expected v=%0b idx=%0d oh=%b",
                 tg, grant_valid_o, grant_idx_o, grant_oh_o, ex[2], ex[1:0], ex_oh);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (grant_valid_o !== 1'b0 || grant_oh_o !== 3'b000) begin
      failures++;
      $display("FAIL R10: reset grant v=%0b oh=%b expected v=0 oh=000", grant_valid_o, grant_oh_o);
    end
    @(negedge clk); rst_n = 1'b1;
    step(3'b000, 0, 0, 0, 3'b000, 0, "R4");
    step(3'b111, 300, 100, 200, 3'b111, 0, "R1");
    step(3'b101, 300, 100, 200, 3'b111, 0, "R1");
    step(3'b101, 300, 100, 200, 3'b111, 0, "R9");
    step(3'b011, 300, 100, 200, 3'b111, 0, "R9");
    step(3'b110, 55, 77, 77, 3'b111, 0, "R2");
    step(3'b111, 77, 77, 77, 3'b111, 0, "R2");
    step(3'b011, 29'h3FFFF, 29'h001, 0, 3'b001, 0, "R3");
    step(3'b011, 29'h40000, 29'h001, 0, 3'b001, 0, "R3");
    step(3'b101, 29'h140000, 0, 29'h7FFFFFF, 3'b001, 0, "R3");
    step(3'b000, 0, 0, 0, 3'b000, 1, "R4");
    step(3'b001, 900, 5, 1, 3'b000, 1, "R5");
    step(3'b011, 900, 5, 1, 3'b000, 0, "R5");
    step(3'b111, 900, 5, 1, 3'b000, 0, "R8");
    step(3'b110, 900, 5, 1, 3'b000, 0, "R5");
    step(3'b100, 900, 5, 1, 3'b000, 0, "R8");
    step(3'b101, 1, 5, 900, 3'b000, 0, "R11");
    step(3'b001, 1, 5, 900, 3'b000, 0, "R11");
    step(3'b000, 0, 0, 0, 3'b000, 0, "R8");
    step(3'b111, 30, 20, 10, 3'b000, 1, "R8");
    step(3'b000, 0, 0, 0, 3'b000, 1, "R4");
    step(3'b110, 9, 9, 9, 3'b000, 1, "R6");
    step(3'b111, 9, 9, 9, 3'b000, 1, "R6");
    step(3'b101, 9, 9, 9, 3'b000, 1, "R6");
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] p;
      p = 3'($urandom_range(0, 7));
      if (n % 5 != 0 && p == 0) p = 3'b001;
      step(p, 29'($urandom_range(0, 3)) << ($urandom_range(0, 1) * 18),
           29'($urandom_range(0, 3)), 29'($urandom_range(0, 3)) << 18,
           3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R7");
    end
    repeat (3) @(posedge clk);
    #5;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule